// File: doc/BRIEF.md
# Parallel ATA Register Cycle Sequencer

This block runs single 8-bit register reads and writes on a parallel ATA-style device bus from the host side. A local requester hands over one transfer at a time: a 4-bit register address, a read/write flag and, for writes, a data byte. The block then drives the pair of active-low chip selects, the three register address lines, the data bus and the read or write strobe through four phases: address setup, strobe active, an optional wait extension and recovery. Each phase length is a count of system clock cycles taken from a plain configuration input.

The device may stretch a cycle by pulling its ready line low. That line first passes through a two-flop synchronizer. The host then looks at it exactly once, at a programmable point after the strobe falls, with the synchronizer delay already counted in. A short dip in ready that clears before that point never adds a wait. A dip that is still present at that point holds the strobe low until ready returns. A watchdog cuts off a wait that runs too long and flags the transfer as timed out.

The request side is a valid/ready interface. `req_ready` is high only while the sequencer is idle, so back-pressure lasts for the whole of a transfer. A request must stay valid until it is accepted. The response is a one-cycle `rsp_valid` pulse that the requester cannot stall.

Top module: `ata_reg_host`

## Requirements
- R1: After reset, both chip selects are high (`ata_cs_n` = 2'b11), both strobes are high, `ata_dd_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the first idle cycle. A request held valid during a transfer starts a new transfer only after the current one completes, and once `req_valid` falls no further transfer starts.
- R3: While a transfer is in progress, `req_addr[3]` = 0 drives `ata_cs_n` = 2'b10 and `req_addr[3]` = 1 drives 2'b01. `ata_da` equals `req_addr[2:0]`. Both stay stable from the start of setup to the end of recovery.
- R4: The chip selects and address are valid for max(1, `cfg_setup`) cycles before the strobe falls.
- R5: With ready held high, the strobe is low for L = max(max(1,`cfg_active`), max(1,`cfg_tsample`)+2) cycles.
- R6: Let T = max(1,`cfg_tsample`). The ready level seen during strobe cycle T alone decides the wait. If `ata_iordy` is low only in strobe cycles 1..T-1, no wait is added and the width is L. If it is low through cycle T, a wait is added.
- R7: In a wait, the strobe stays low until the synchronized ready is high. If `ata_iordy` is low in strobe cycles 1..N with N+3 > L, the strobe is low for N+3 cycles.
- R8: On a read, `ata_dd_oe` stays 0. `ata_dd_in` is captured on the clock edge that ends the strobe and is presented on `rsp_rdata` with `rsp_valid`.
- R9: On a write, `ata_dd_oe` is 1 and `ata_dd_out` equals the write data in every cycle a chip select is low. Only `ata_wr_n` strobes, and `ata_rd_n` stays high.
- R10: The chip selects stay low for max(1,`cfg_recover`) cycles after the strobe rises. `rsp_valid` is then high for exactly one cycle, in the first idle cycle.
- R11: If a wait lasts max(1,`cfg_wdog`) cycles without ready, the strobe rises after exactly that many wait cycles, `rsp_timeout` is 1 and `rsp_rdata` is 0. Otherwise `rsp_timeout` is 0.
- R12: A configuration value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = register write, 0 = read |
| req_addr | input | 4 | Bit 3 picks chip select, bits 2:0 register |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data |
| rsp_timeout | output | 1 | Wait ended by watchdog |
| cfg_setup | input | CNT_W | Setup cycles |
| cfg_active | input | CNT_W | Minimum strobe cycles |
| cfg_tsample | input | CNT_W | Ready decision point, in strobe cycles |
| cfg_recover | input | CNT_W | Recovery cycles |
| cfg_wdog | input | WD_W | Wait limit in cycles |
| ata_cs_n | output | 2 | Active-low chip selects |
| ata_da | output | 3 | Register address lines |
| ata_dd_out | output | 8 | Data bus out |
| ata_dd_oe | output | 1 | Data bus drive enable |
| ata_dd_in | input | 8 | Data bus in |
| ata_rd_n | output | 1 | Active-low read strobe |
| ata_wr_n | output | 1 | Active-low write strobe |
| ata_iordy | input | 1 | Device ready, asynchronous |

## Verification
Ready is driven in four patterns. In the first it is never dropped, which sets the baseline strobe width. In the second it is low for one cycle fewer than the decision point, and in the third it is low exactly through the decision point. Those two patterns lie on either side of the single-sample rule, so they separate a correct sample point from one placed a cycle early or late, or from a design that watches ready continuously. In the fourth pattern ready stays low long enough to trip the watchdog, which checks the timeout flag and the forced-zero read data. Reads and writes on both chip selects, all-zero configuration and a request held valid across a transfer cover the address decode, the rule that 0 acts as 1, and the handshake.

// File: rtl/ata_host_pkg.sv
package ata_host_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_WAIT,
    PH_RECOVER
  } phase_e;

  localparam int RDY_SYNC_STAGES = 2;
endpackage

// File: rtl/ata_rdy_sync.sv
module ata_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ata_phase_timer.sv
module ata_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] elapsed
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 elapsed <= '0;
    else if (restart)           elapsed <= '0;
    else if (elapsed != '1)     elapsed <= elapsed + 1'b1;
endmodule

// File: rtl/ata_reg_host.sv
module ata_reg_host
  import ata_host_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int WD_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [3:0]       req_addr,
  input  logic [7:0]       req_wdata,
  output logic             rsp_valid,
  output logic [7:0]       rsp_rdata,
  output logic             rsp_timeout,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_active,
  input  logic [CNT_W-1:0] cfg_tsample,
  input  logic [CNT_W-1:0] cfg_recover,
  input  logic [WD_W-1:0]  cfg_wdog,
  output logic [1:0]       ata_cs_n,
  output logic [2:0]       ata_da,
  output logic [7:0]       ata_dd_out,
  output logic             ata_dd_oe,
  input  logic [7:0]       ata_dd_in,
  output logic             ata_rd_n,
  output logic             ata_wr_n,
  input  logic             ata_iordy
);
  localparam int PW = (WD_W > CNT_W + 2) ? WD_W : CNT_W + 2;

  function automatic logic [PW-1:0] floor_one(input logic [PW-1:0] v);
    return (v == '0) ? PW'(1) : v;
  endfunction

  phase_e           phase, phase_nxt;
  logic [PW-1:0]    elapsed, tick;
  logic [PW-1:0]    setup_len, active_min, sample_at, strobe_len, recov_len, wdog_len;
  logic             rdy_s;
  logic             write_q, wait_flag, timeout_q, rsp_valid_q;
  logic [3:0]       addr_q;
  logic [7:0]       wdata_q, rdata_q;
  logic             accept, sample_now, want_wait, strobe_end_ok, wdog_hit;

  ata_rdy_sync #(.STAGES(RDY_SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ata_iordy),
    .sync_out (rdy_s)
  );

  ata_phase_timer #(.W(PW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (phase_nxt != phase),
    .elapsed (elapsed)
  );

  always_comb begin
    setup_len  = floor_one(PW'(cfg_setup));
    active_min = floor_one(PW'(cfg_active));
    sample_at  = floor_one(PW'(cfg_tsample)) + PW'(RDY_SYNC_STAGES);
    strobe_len = (active_min > sample_at) ? active_min : sample_at;
    recov_len  = floor_one(PW'(cfg_recover));
    wdog_len   = floor_one(PW'(cfg_wdog));
    tick       = elapsed + 1'b1;
  end

  assign accept     = (phase == PH_IDLE) && req_valid;
  assign sample_now = (phase == PH_ACTIVE) && (tick == sample_at);
  assign want_wait  = sample_now ? !rdy_s : wait_flag;
  assign strobe_end_ok = ((phase == PH_ACTIVE) && (tick >= strobe_len) && !want_wait) ||
                         ((phase == PH_WAIT) && rdy_s);
  assign wdog_hit   = (phase == PH_WAIT) && !rdy_s && (tick >= wdog_len);

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE:    if (req_valid) phase_nxt = PH_SETUP;
      PH_SETUP:   if (tick >= setup_len) phase_nxt = PH_ACTIVE;
      PH_ACTIVE:  if (tick >= strobe_len) phase_nxt = want_wait ? PH_WAIT : PH_RECOVER;
      PH_WAIT:    if (rdy_s || wdog_hit) phase_nxt = PH_RECOVER;
      PH_RECOVER: if (tick >= recov_len) phase_nxt = PH_IDLE;
      default:    phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      write_q     <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      wait_flag   <= 1'b0;
      rdata_q     <= '0;
      timeout_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
    end else begin
      phase       <= phase_nxt;
      rsp_valid_q <= (phase == PH_RECOVER) && (phase_nxt == PH_IDLE);
      if (accept) begin
        write_q   <= req_write;
        addr_q    <= req_addr;
        wdata_q   <= req_wdata;
        wait_flag <= 1'b0;
        timeout_q <= 1'b0;
      end
      if (sample_now) wait_flag <= !rdy_s;
      if (strobe_end_ok && !write_q) rdata_q <= ata_dd_in;
      if (wdog_hit) begin
        rdata_q   <= '0;
        timeout_q <= 1'b1;
      end
    end
  end

  always_comb begin
    logic busy, strobing;
    busy     = (phase != PH_IDLE);
    strobing = (phase == PH_ACTIVE) || (phase == PH_WAIT);
    ata_cs_n   = !busy ? 2'b11 : (addr_q[3] ? 2'b01 : 2'b10);
    ata_da     = busy ? addr_q[2:0] : 3'b000;
    ata_dd_oe  = busy && write_q;
    ata_dd_out = wdata_q;
    ata_rd_n   = !(strobing && !write_q);
    ata_wr_n   = !(strobing && write_q);
  end

  assign req_ready   = (phase == PH_IDLE);
  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rdata_q;
  assign rsp_timeout = timeout_q;
endmodule

// File: rtl/ata_reg_host_chk.sv
module ata_reg_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic [1:0] ata_cs_n,
  input logic [2:0] ata_da,
  input logic       ata_dd_oe,
  input logic       ata_rd_n,
  input logic       ata_wr_n
);
  // R9
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_rd_n && !ata_wr_n));
  // R3
  single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ata_cs_n) <= 1);
  // R4
  strobe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_rd_n || !ata_wr_n) |-> (ata_cs_n != 2'b11));
  // R3
  address_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ata_cs_n != 2'b11) && $past(ata_cs_n != 2'b11)) |-> ($stable(ata_da) && $stable(ata_cs_n)));
  // R8
  read_bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_rd_n |-> !ata_dd_oe);
  // R10
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (ata_cs_n == 2'b11));
  // R2
  ready_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ata_cs_n == 2'b11 && ata_rd_n && ata_wr_n && !ata_dd_oe));
endmodule

bind ata_reg_host ata_reg_host_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ata_cs_n  (ata_cs_n),
  .ata_da    (ata_da),
  .ata_dd_oe (ata_dd_oe),
  .ata_rd_n  (ata_rd_n),
  .ata_wr_n  (ata_wr_n)
);

// File: tb/tb_ata_reg_host.sv
`timescale 1ns/1ps
module tb_ata_reg_host;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, rsp_valid, rsp_timeout;
  logic [7:0] rsp_rdata;
  logic [7:0] cfg_setup = 8'd2, cfg_active = 8'd4, cfg_tsample = 8'd3, cfg_recover = 8'd2;
  logic [15:0] cfg_wdog = 16'd100;
  logic [1:0] ata_cs_n;
  logic [2:0] ata_da;
  logic [7:0] ata_dd_out, ata_dd_in = 8'h00;
  logic       ata_dd_oe, ata_rd_n, ata_wr_n;
  logic       ata_iordy = 1'b1;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int m_setup, m_strobe, m_recov, m_viol, m_tmo;
  logic [7:0] m_rdata;
  bit m_pulse_ok;

  always #10 clk = ~clk;

  ata_reg_host dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
    .cfg_setup(cfg_setup), .cfg_active(cfg_active), .cfg_tsample(cfg_tsample),
    .cfg_recover(cfg_recover), .cfg_wdog(cfg_wdog), .ata_cs_n(ata_cs_n),
    .ata_da(ata_da), .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe),
    .ata_dd_in(ata_dd_in), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n),
    .ata_iordy(ata_iordy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One transfer; ready low during strobe cycles 1..nlow
  task automatic run_xfer(input bit wr, input logic [3:0] a, input logic [7:0] wd, input int nlow);
    logic [1:0] exp_cs;
    bit done;
    exp_cs = a[3] ? 2'b01 : 2'b10;
    m_setup = 0; m_strobe = 0; m_recov = 0; m_viol = 0; done = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    for (int i = 0; i < 2000 && !done; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (rsp_valid) begin
        m_rdata = rsp_rdata; m_tmo = rsp_timeout; done = 1'b1;
        if (ata_cs_n != 2'b11) m_viol++;
      end else if (ata_cs_n != 2'b11) begin
        if (ata_cs_n != exp_cs || ata_da != a[2:0] || ata_dd_oe != wr || req_ready) m_viol++;
        if (wr && (ata_dd_out != wd || !ata_rd_n)) m_viol++;
        if (!wr && !ata_wr_n) m_viol++;
        if ((wr ? ata_wr_n : ata_rd_n) == 1'b0) begin
          m_strobe++;
          ata_iordy = (m_strobe <= nlow) ? 1'b0 : 1'b1;
        end else begin
          ata_iordy = 1'b1;
          if (m_strobe == 0) m_setup++; else m_recov++;
        end
      end
    end
    ata_iordy = 1'b1;
    @(negedge clk);
    m_pulse_ok = !rsp_valid && req_ready;
  endtask

  task automatic t_reset;
    chk(ata_cs_n == 2'b11 && ata_rd_n && ata_wr_n && !ata_dd_oe, "R1 bus idle", ata_cs_n, 3);
    chk(req_ready && !rsp_valid, "R1 handshake idle", {req_ready, rsp_valid}, 2);
  endtask

  task automatic t_basic_read;
    ata_dd_in = 8'hC3;
    run_xfer(1'b0, 4'b0110, 8'h00, 0);
    chk(m_setup == 2, "R4 setup cycles", m_setup, 2);
    chk(m_strobe == 5, "R5 strobe width", m_strobe, 5);
    chk(m_recov == 2, "R10 recovery cycles", m_recov, 2);
    chk(m_rdata == 8'hC3, "R8 read data", m_rdata, 8'hC3);
    chk(m_viol == 0, "R3 R8 R2 per-cycle bus", m_viol, 0);
    chk(m_pulse_ok, "R10 single done pulse", m_pulse_ok, 1);
    chk(m_tmo == 0, "R11 no timeout", m_tmo, 0);
  endtask

  task automatic t_write_cs1;
    run_xfer(1'b1, 4'b1101, 8'hA5, 0);
    chk(m_viol == 0, "R9 R3 write drive and select", m_viol, 0);
    chk(m_strobe == 5 && m_setup == 2, "R9 write strobe", m_strobe, 5);
  endtask

  task automatic t_brief_dip;
    ata_dd_in = 8'h11;
    run_xfer(1'b0, 4'b0001, 8'h00, 2);
    chk(m_strobe == 5, "R6 dip before sample point", m_strobe, 5);
    chk(m_rdata == 8'h11, "R6 data", m_rdata, 8'h11);
  endtask

  task automatic t_dip_at_point;
    run_xfer(1'b0, 4'b0010, 8'h00, 3);
    chk(m_strobe == 6, "R6 R7 dip at sample point", m_strobe, 6);
  endtask

  task automatic t_long_wait;
    ata_dd_in = 8'h7E;
    run_xfer(1'b0, 4'b1011, 8'h00, 20);
    chk(m_strobe == 23, "R7 long wait width", m_strobe, 23);
    chk(m_rdata == 8'h7E, "R8 data after wait", m_rdata, 8'h7E);
    chk(m_tmo == 0, "R11 wait no timeout", m_tmo, 0);
  endtask

  task automatic t_timeout;
    cfg_wdog = 16'd10;
    ata_dd_in = 8'hFF;
    run_xfer(1'b0, 4'b0100, 8'h00, 1000);
    chk(m_strobe == 15, "R11 strobe cut at limit", m_strobe, 15);
    chk(m_tmo == 1, "R11 timeout flag", m_tmo, 1);
    chk(m_rdata == 8'h00, "R11 zero data", m_rdata, 0);
    cfg_wdog = 16'd100;
  endtask

  task automatic t_zero_cfg;
    cfg_setup = 0; cfg_active = 0; cfg_tsample = 0; cfg_recover = 0;
    run_xfer(1'b1, 4'b0011, 8'h3C, 0);
    chk(m_setup == 1, "R12 setup zero", m_setup, 1);
    chk(m_strobe == 3, "R12 strobe zero", m_strobe, 3);
    chk(m_recov == 1, "R12 recovery zero", m_recov, 1);
    cfg_setup = 2; cfg_active = 4; cfg_tsample = 3; cfg_recover = 2;
  endtask

  task automatic t_held_request;
    int pulses, strobes, busy_ready;
    bit dropped, prev_low;
    logic [7:0] second_dd;
    pulses = 0; strobes = 0; busy_ready = 0; dropped = 0; prev_low = 0; second_dd = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'b0101; req_wdata = 8'h96;
    for (int i = 0; i < 500 && pulses < 2; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        pulses++;
        req_wdata = 8'h5A;
      end else if (ata_cs_n != 2'b11) begin
        if (req_ready) busy_ready++;
        if (pulses == 1 && !dropped) begin
          req_valid = 1'b0; dropped = 1'b1; second_dd = ata_dd_out;
        end
      end
      if (!ata_wr_n && !prev_low) strobes++;
      prev_low = !ata_wr_n;
    end
    req_valid = 1'b0;
    chk(pulses == 2 && strobes == 2, "R2 held request gives two transfers", strobes, 2);
    chk(second_dd == 8'h5A, "R2 second transfer data", second_dd, 8'h5A);
    chk(busy_ready == 0, "R2 ready low while busy", busy_ready, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ata_cs_n != 2'b11) busy_ready++;
    end
    chk(busy_ready == 0, "R2 no transfer after valid drops", busy_ready, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic_read();
    t_write_cs1();
    t_brief_dip();
    t_dip_at_point();
    t_long_wait();
    t_timeout();
    t_zero_cfg();
    t_held_request();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule